// File: doc/BRIEF.md
# Audio Sample Word Formatter

This block sits between the 32-bit sample FIFOs of a digital audio interface and the biphase-mark line coder. On the transmit side it takes words from a FIFO over a valid/ready handshake. It hands one subframe to the serializer for each request. A subframe is a 24-bit audio slot plus validity, user, channel-status and parity bits and a 4-bit preamble code. The block keeps track of whether the next subframe belongs to the left or the right channel.

On the receive side it turns subframes recovered by the deserializer into FIFO words. The receive side does not start capturing until it sees the configured start channel.

The block has five word layouts. A 2-bit width code selects 16, 20 or 24-bit samples, or raw subframe data with explicit flag and preamble bits. A pack flag, honoured only at 16-bit width, carries a left/right sample pair in one FIFO word. Line coding, FIFO storage and the sources of channel-status and user bits are outside this block.

Top module: `asw_formatter`

## Requirements
- R1: While reset is held, and on the first cycle after it, `tx_sub_valid`, `tx_underrun`, `rx_word_valid` and `rx_overrun` are 0. The first transmit subframe after reset is a left subframe.
- R2: `cfg_width` selects the layout: 0 = 16-bit, 1 = 20-bit, 2 = 24-bit, 3 = raw. In the three sample modes the transmit sample is taken right-justified from the FIFO word, starting at bit 0. It is placed MSB-aligned in the 24-bit slot, and the unused low slot bits are 0.
- R3: In raw transmit mode, FIFO word bit 31 is P, bit 30 is C, bit 29 is U and bit 28 is V. Bits 27:4 form the 24-bit slot: 20 audio bits in 27:8 and 4 auxiliary bits in 7:4. Bits 3:0 are the preamble code. All of these pass through unchanged, P included.
- R4: In the sample modes V, U and C come from `tx_vflag`, `tx_ubit` and `tx_cbit`. P makes the count of ones over slot, V, U, C and P even. The preamble code is 4'h1 for a left subframe and 4'h2 for a right subframe.
- R5: Each cycle with `tx_req` high produces a subframe with `tx_sub_valid` high on the next cycle. Successive subframes alternate between left and right, and `tx_sub_left` marks the channel.
- R6: `tx_ready` is high only in a cycle with `tx_req` and `tx_valid` both high. When unpacked, every request that finds a word pops exactly that word.
- R7: In packed mode (`cfg_pack`=1 with `cfg_width`=0), bits 15:0 feed the left subframe and bits 31:16 feed the right subframe. The word is popped only on the right-channel request. With any other width the pack flag is ignored.
- R8: A request made while `tx_valid` is low yields a subframe with a zero slot, V=1, correct parity and the channel preamble code, with `tx_underrun` high. Nothing is popped, and the channel sequence still advances.
- R9: An unpacked receive word carries P, C, U, V in bits 31:28 and the preamble code in 27:24. Bits 23:0 hold slot[23:8] in 15:0 for 16-bit width, slot[23:4] in 19:0 for 20-bit width, or the full slot for 24-bit and raw. Unused bits are 0. The word is valid on the cycle after its subframe.
- R10: After reset, received subframes are discarded until one arrives whose channel equals `cfg_rx_start_left` (1 = left, 0 = right). That subframe and all later ones are captured.
- R11: In packed receive mode a pair starts with the start-channel subframe. The left sample's slot[23:8] goes to bits 15:0 and the right sample's goes to bits 31:16. The word is valid on the cycle after the second subframe of the pair.
- R12: A receive word stays valid and unchanged until `rx_word_ready` is high. A word completed while the previous one is held and not accepted is dropped, and `rx_overrun` is high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_width | input | 2 | Width code: 0=16, 1=20, 2=24, 3=raw |
| cfg_pack | input | 1 | Two 16-bit samples per FIFO word |
| cfg_rx_start_left | input | 1 | Capture starts on left (1) or right (0) |
| tx_word | input | 32 | Transmit FIFO head word |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_ready | output | 1 | Pop the transmit FIFO head word |
| tx_req | input | 1 | Serializer asks for the next subframe |
| tx_vflag | input | 1 | Validity bit for sample modes |
| tx_ubit | input | 1 | User bit for sample modes |
| tx_cbit | input | 1 | Channel-status bit for sample modes |
| tx_sub_valid | output | 1 | Subframe outputs are valid |
| tx_sub_left | output | 1 | Subframe belongs to the left channel |
| tx_sub_slot | output | 24 | Audio slot |
| tx_sub_v | output | 1 | Validity bit |
| tx_sub_u | output | 1 | User bit |
| tx_sub_c | output | 1 | Channel-status bit |
| tx_sub_p | output | 1 | Parity bit |
| tx_sub_pre | output | 4 | Preamble code |
| tx_underrun | output | 1 | Subframe was built with no FIFO word |
| rx_sub_valid | input | 1 | Received subframe is present |
| rx_sub_left | input | 1 | Received subframe is left channel |
| rx_sub_slot | input | 24 | Received audio slot |
| rx_sub_v | input | 1 | Received validity bit |
| rx_sub_u | input | 1 | Received user bit |
| rx_sub_c | input | 1 | Received channel-status bit |
| rx_sub_p | input | 1 | Received parity bit |
| rx_sub_pre | input | 4 | Received preamble code |
| rx_word | output | 32 | Receive FIFO word |
| rx_word_valid | output | 1 | Receive word available |
| rx_word_ready | input | 1 | Receive FIFO accepts the word |
| rx_overrun | output | 1 | A completed word was dropped |

## Verification
`tx_ready` is combinational and is due in the same cycle as the request that causes it. The bench therefore compares it at the rising edge, against a value predicted from the inputs driven at the previous falling edge. Each transmit subframe, `tx_underrun`, each receive word and `rx_overrun` are registered and are due one cycle after their stimulus. The bench reference model updates its predictions at that same rising edge and compares them with the outputs at the following falling edge. A held receive word is compared on every cycle until it is accepted, and the discarded pre-lock subframes are checked through `rx_word_valid` staying low.

// File: rtl/asw_fmt_pkg.sv
// Shared constants, types and helpers for the audio sample word formatter.
package asw_fmt_pkg;

    localparam int WORD_W = 32;
    localparam int SLOT_W = 24;
    localparam int PRE_W  = 4;
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [1:0] {
        WM_16  = 2'd0,
        WM_20  = 2'd1,
        WM_24  = 2'd2,
        WM_RAW = 2'd3
    } width_mode_e;

    localparam logic [PRE_W-1:0] PRE_LEFT  = 4'h1;
    localparam logic [PRE_W-1:0] PRE_RIGHT = 4'h2;

    typedef struct packed {
        logic              p;
        logic              c;
        logic              u;
        logic              v;
        logic [PRE_W-1:0]  pre;
        logic [SLOT_W-1:0] slot;
    } subframe_t;

    // Even-parity bit over slot and V/U/C flags.
    function automatic logic even_par(input logic [SLOT_W-1:0] slot,
                                      input logic v, input logic u, input logic c);
        return ^{slot, v, u, c};
    endfunction

endpackage

// File: rtl/asw_tx_packer.sv
// Transmit formatter: builds one subframe per serializer request from the
// head word of the transmit FIFO. Assumes the FIFO holds word and valid
// stable until popped, and that configuration changes only between streams.
module asw_tx_packer
    import asw_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  width_mode_e       width_i,
    input  logic              pack_i,
    input  logic              vflag_i,
    input  logic              ubit_i,
    input  logic              cbit_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_valid_i,
    output logic              word_ready_o,
    input  logic              req_i,
    output subframe_t         sub_o,
    output logic              sub_valid_o,
    output logic              sub_left_o,
    output logic              underrun_o
);

    logic      next_left_q;
    logic      pack_eff;
    subframe_t sub_d;

    assign pack_eff = pack_i && (width_i == WM_16);

    // Pop on every unpacked request, or on the right half of a packed pair.
    assign word_ready_o = req_i && word_valid_i && (!pack_eff || !next_left_q);

    // Assemble the next subframe from the FIFO head word and flag inputs.
    always_comb begin
        sub_d      = '0;
        sub_d.pre  = next_left_q ? PRE_LEFT : PRE_RIGHT;
        sub_d.v    = vflag_i;
        sub_d.u    = ubit_i;
        sub_d.c    = cbit_i;
        if (!word_valid_i) begin
            sub_d.v    = 1'b1;
            sub_d.slot = '0;
        end else if (width_i == WM_RAW) begin
            sub_d.slot = word_i[27:4];
            sub_d.pre  = word_i[3:0];
            sub_d.v    = word_i[28];
            sub_d.u    = word_i[29];
            sub_d.c    = word_i[30];
        end else if (pack_eff) begin
            sub_d.slot = {(next_left_q ? word_i[HALF_W-1:0] : word_i[WORD_W-1:HALF_W]),
                          {(SLOT_W-HALF_W){1'b0}}};
        end else begin
            unique case (width_i)
                WM_16:   sub_d.slot = {word_i[15:0], 8'h00};
                WM_20:   sub_d.slot = {word_i[19:0], 4'h0};
                default: sub_d.slot = word_i[SLOT_W-1:0];
            endcase
        end
        if (word_valid_i && width_i == WM_RAW)
            sub_d.p = word_i[31];
        else
            sub_d.p = even_par(sub_d.slot, sub_d.v, sub_d.u, sub_d.c);
    end

    // Register the subframe and advance the channel on each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_left_q <= 1'b1;
            sub_valid_o <= 1'b0;
            underrun_o  <= 1'b0;
            sub_left_o  <= 1'b0;
            sub_o       <= '0;
        end else begin
            sub_valid_o <= req_i;
            underrun_o  <= req_i && !word_valid_i;
            if (req_i) begin
                sub_o       <= sub_d;
                sub_left_o  <= next_left_q;
                next_left_q <= !next_left_q;
            end
        end
    end

endmodule

// File: rtl/asw_rx_unpacker.sv
// Receive formatter: turns captured subframes into FIFO words after locking
// onto the configured start channel. Holds one word until the FIFO accepts
// it. Assumes configuration changes only with reset.
module asw_rx_unpacker
    import asw_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  width_mode_e       width_i,
    input  logic              pack_i,
    input  logic              start_left_i,
    input  subframe_t         sub_i,
    input  logic              sub_valid_i,
    input  logic              sub_left_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o,
    input  logic              word_ready_i,
    output logic              overrun_o
);

    logic              locked_q;
    logic              have_q;
    logic [WORD_W-1:0] acc_q;
    logic              pack_eff;
    logic              take;
    logic              complete;
    logic              can_load;
    logic [WORD_W-1:0] half_w;
    logic [WORD_W-1:0] fmt_w;
    logic [WORD_W-1:0] new_w;
    logic [SLOT_W-1:0] body;

    assign pack_eff = pack_i && (width_i == WM_16);
    assign take     = sub_valid_i && (locked_q || (sub_left_i == start_left_i));
    assign complete = take && (!pack_eff || have_q);
    assign can_load = !word_valid_o || word_ready_i;

    // Place a 16-bit sample in the half of the word that matches its channel.
    always_comb begin
        if (sub_left_i)
            half_w = {{HALF_W{1'b0}}, sub_i.slot[SLOT_W-1 -: HALF_W]};
        else
            half_w = {sub_i.slot[SLOT_W-1 -: HALF_W], {HALF_W{1'b0}}};
    end

    // Right-justify the sample for the unpacked layouts.
    always_comb begin
        unique case (width_i)
            WM_16:   body = {8'h00, sub_i.slot[23:8]};
            WM_20:   body = {4'h0, sub_i.slot[23:4]};
            default: body = sub_i.slot;
        endcase
        fmt_w = {sub_i.p, sub_i.c, sub_i.u, sub_i.v, sub_i.pre, body};
        new_w = pack_eff ? (acc_q | half_w) : fmt_w;
    end

    // Track lock and pair state, and load or drop completed words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q     <= 1'b0;
            have_q       <= 1'b0;
            acc_q        <= '0;
            word_o       <= '0;
            word_valid_o <= 1'b0;
            overrun_o    <= 1'b0;
        end else begin
            if (take) begin
                locked_q <= 1'b1;
                if (pack_eff && !have_q) begin
                    acc_q  <= half_w;
                    have_q <= 1'b1;
                end else begin
                    have_q <= 1'b0;
                end
            end
            overrun_o <= complete && !can_load;
            if (complete && can_load) begin
                word_o       <= new_w;
                word_valid_o <= 1'b1;
            end else if (word_ready_i) begin
                word_valid_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/asw_formatter.sv
// Top of the audio sample word formatter: joins the transmit packer and the
// receive unpacker and maps their structured ports onto flat pins.
module asw_formatter
    import asw_fmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_width,
    input  logic                 cfg_pack,
    input  logic                 cfg_rx_start_left,
    input  logic [WORD_W-1:0]    tx_word,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    input  logic                 tx_req,
    input  logic                 tx_vflag,
    input  logic                 tx_ubit,
    input  logic                 tx_cbit,
    output logic                 tx_sub_valid,
    output logic                 tx_sub_left,
    output logic [SLOT_W-1:0]    tx_sub_slot,
    output logic                 tx_sub_v,
    output logic                 tx_sub_u,
    output logic                 tx_sub_c,
    output logic                 tx_sub_p,
    output logic [PRE_W-1:0]     tx_sub_pre,
    output logic                 tx_underrun,
    input  logic                 rx_sub_valid,
    input  logic                 rx_sub_left,
    input  logic [SLOT_W-1:0]    rx_sub_slot,
    input  logic                 rx_sub_v,
    input  logic                 rx_sub_u,
    input  logic                 rx_sub_c,
    input  logic                 rx_sub_p,
    input  logic [PRE_W-1:0]     rx_sub_pre,
    output logic [WORD_W-1:0]    rx_word,
    output logic                 rx_word_valid,
    input  logic                 rx_word_ready,
    output logic                 rx_overrun
);

    width_mode_e width_m;
    subframe_t   tx_sub;
    subframe_t   rx_sub;

    assign width_m = width_mode_e'(cfg_width);

    // Flatten the transmit subframe onto output pins.
    assign tx_sub_slot = tx_sub.slot;
    assign tx_sub_v    = tx_sub.v;
    assign tx_sub_u    = tx_sub.u;
    assign tx_sub_c    = tx_sub.c;
    assign tx_sub_p    = tx_sub.p;
    assign tx_sub_pre  = tx_sub.pre;

    // Gather the receive pins into a subframe.
    assign rx_sub = '{p: rx_sub_p, c: rx_sub_c, u: rx_sub_u, v: rx_sub_v,
                      pre: rx_sub_pre, slot: rx_sub_slot};

    asw_tx_packer u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .width_i      (width_m),
        .pack_i       (cfg_pack),
        .vflag_i      (tx_vflag),
        .ubit_i       (tx_ubit),
        .cbit_i       (tx_cbit),
        .word_i       (tx_word),
        .word_valid_i (tx_valid),
        .word_ready_o (tx_ready),
        .req_i        (tx_req),
        .sub_o        (tx_sub),
        .sub_valid_o  (tx_sub_valid),
        .sub_left_o   (tx_sub_left),
        .underrun_o   (tx_underrun)
    );

    asw_rx_unpacker u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .width_i      (width_m),
        .pack_i       (cfg_pack),
        .start_left_i (cfg_rx_start_left),
        .sub_i        (rx_sub),
        .sub_valid_i  (rx_sub_valid),
        .sub_left_i   (rx_sub_left),
        .word_o       (rx_word),
        .word_valid_o (rx_word_valid),
        .word_ready_i (rx_word_ready),
        .overrun_o    (rx_overrun)
    );

endmodule

// File: rtl/asw_formatter_checker.sv
// Protocol checker for asw_formatter, attached by bind below.
module asw_formatter_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_width,
    input logic        cfg_pack,
    input logic        tx_req,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        tx_sub_valid,
    input logic        tx_sub_left,
    input logic [23:0] tx_sub_slot,
    input logic        tx_sub_v,
    input logic        tx_sub_u,
    input logic        tx_sub_c,
    input logic        tx_sub_p,
    input logic        tx_underrun,
    input logic [31:0] rx_word,
    input logic        rx_word_valid,
    input logic        rx_word_ready
);

    logic seen_q;
    logic last_left_q;

    // Remember the channel of the previous subframe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            last_left_q <= 1'b0;
        end else if (tx_sub_valid) begin
            seen_q      <= 1'b1;
            last_left_q <= tx_sub_left;
        end
    end

    a_r5_req_answered: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_sub_valid);

    a_r5_channel_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sub_valid && seen_q) |-> (tx_sub_left != last_left_q));

    a_r4_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && cfg_width != 2'd3) |=>
            (^{tx_sub_slot, tx_sub_v, tx_sub_u, tx_sub_c, tx_sub_p} == 1'b0));

    a_r6_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (tx_req && tx_valid));

    a_r7_pop_on_right: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && cfg_pack && cfg_width == 2'd0) |=> !tx_sub_left);

    a_r8_underrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_valid) |=> (tx_underrun && tx_sub_v));

    a_r12_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_valid && !rx_word_ready) |=> (rx_word_valid && $stable(rx_word)));

endmodule

bind asw_formatter asw_formatter_checker u_asw_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_width     (cfg_width),
    .cfg_pack      (cfg_pack),
    .tx_req        (tx_req),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_sub_valid  (tx_sub_valid),
    .tx_sub_left   (tx_sub_left),
    .tx_sub_slot   (tx_sub_slot),
    .tx_sub_v      (tx_sub_v),
    .tx_sub_u      (tx_sub_u),
    .tx_sub_c      (tx_sub_c),
    .tx_sub_p      (tx_sub_p),
    .tx_underrun   (tx_underrun),
    .rx_word       (rx_word),
    .rx_word_valid (rx_word_valid),
    .rx_word_ready (rx_word_ready)
);

// File: tb/asw_formatter_bench.sv
// Self-checking bench with a behavioural reference model compared each clock.
module asw_formatter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic        cfg_pack = 1'b0;
    logic        cfg_rx_start_left = 1'b1;
    logic [31:0] tx_word = 32'h0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        tx_req = 1'b0;
    logic        tx_vflag = 1'b0;
    logic        tx_ubit = 1'b0;
    logic        tx_cbit = 1'b0;
    logic        tx_sub_valid;
    logic        tx_sub_left;
    logic [23:0] tx_sub_slot;
    logic        tx_sub_v, tx_sub_u, tx_sub_c, tx_sub_p;
    logic [3:0]  tx_sub_pre;
    logic        tx_underrun;
    logic        rx_sub_valid = 1'b0;
    logic        rx_sub_left = 1'b0;
    logic [23:0] rx_sub_slot = 24'h0;
    logic        rx_sub_v = 1'b0, rx_sub_u = 1'b0, rx_sub_c = 1'b0, rx_sub_p = 1'b0;
    logic [3:0]  rx_sub_pre = 4'h0;
    logic [31:0] rx_word;
    logic        rx_word_valid;
    logic        rx_word_ready = 1'b1;
    logic        rx_overrun;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    asw_formatter u_asw_formatter (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] fifo_q[$];
    bit          fifo_pop = 0;
    bit          m_next_left = 1;
    bit          e_sv = 0, e_left = 0, e_und = 0;
    logic [23:0] e_slot = 0;
    bit          e_v = 0, e_u = 0, e_c = 0, e_p = 0;
    logic [3:0]  e_pre = 0;
    bit          m_lock = 0, m_have = 0, m_wv = 0, e_ovr = 0;
    logic [31:0] m_acc = 0, m_w = 0;

    function automatic logic [31:0] rx_half(input bit left, input logic [23:0] s);
        return left ? {16'h0, s[23:8]} : {s[23:8], 16'h0};
    endfunction

    task automatic rx_deliver(input logic [31:0] w);
        if (!m_wv) begin m_w = w; m_wv = 1; end
        else e_ovr = 1;
    endtask

    always @(posedge clk) begin
        bit pk;
        bit exp_rdy;
        logic [31:0] w;
        logic [23:0] body;
        fifo_pop = tx_valid && tx_ready;
        pk = cfg_pack && cfg_width == 2'd0;
        if (!rst_n) begin
            m_next_left = 1; e_sv = 0; e_und = 0;
            m_lock = 0; m_have = 0; m_wv = 0; e_ovr = 0; m_acc = 0;
        end else begin
            exp_rdy = tx_req && tx_valid && (!pk || !m_next_left);
            chk(tx_ready === exp_rdy, "R6", "tx_ready", {31'h0, tx_ready}, {31'h0, exp_rdy});
            e_sv = tx_req;
            e_und = tx_req && !tx_valid;
            if (tx_req) begin
                e_left = m_next_left;
                e_pre = m_next_left ? 4'h1 : 4'h2;
                e_v = tx_vflag; e_u = tx_ubit; e_c = tx_cbit;
                if (!tx_valid) begin
                    e_slot = 0; e_v = 1;
                end else if (cfg_width == 2'd3) begin
                    e_slot = tx_word[27:4]; e_pre = tx_word[3:0];
                    e_v = tx_word[28]; e_u = tx_word[29]; e_c = tx_word[30];
                end else if (pk) begin
                    e_slot = m_next_left ? {tx_word[15:0], 8'h0} : {tx_word[31:16], 8'h0};
                end else if (cfg_width == 2'd0) e_slot = {tx_word[15:0], 8'h0};
                else if (cfg_width == 2'd1) e_slot = {tx_word[19:0], 4'h0};
                else e_slot = tx_word[23:0];
                if (tx_valid && cfg_width == 2'd3) e_p = tx_word[31];
                else e_p = (($countones(e_slot) + e_v + e_u + e_c) % 2) == 1;
                m_next_left = !m_next_left;
            end
            // receive side
            e_ovr = 0;
            if (m_wv && rx_word_ready) m_wv = 0;
            if (rx_sub_valid) begin
                if (!m_lock && rx_sub_left == cfg_rx_start_left) m_lock = 1;
                if (m_lock) begin
                    if (pk) begin
                        if (!m_have) begin m_acc = rx_half(rx_sub_left, rx_sub_slot); m_have = 1; end
                        else begin m_have = 0; rx_deliver(m_acc | rx_half(rx_sub_left, rx_sub_slot)); end
                    end else begin
                        m_have = 0;
                        if (cfg_width == 2'd0) body = {8'h0, rx_sub_slot[23:8]};
                        else if (cfg_width == 2'd1) body = {4'h0, rx_sub_slot[23:4]};
                        else body = rx_sub_slot;
                        w = {rx_sub_p, rx_sub_c, rx_sub_u, rx_sub_v, rx_sub_pre, body};
                        rx_deliver(w);
                    end
                end
            end
        end
    end

    // Compare registered outputs away from the active edge.
    always @(negedge clk) begin
        string sr;
        sr = e_und ? "R8" : (cfg_width == 2'd3) ? "R3" :
             (cfg_pack && cfg_width == 2'd0) ? "R7" : "R2";
        chk(tx_sub_valid === e_sv, "R5", "tx_sub_valid", {31'h0, tx_sub_valid}, {31'h0, e_sv});
        chk(tx_underrun === e_und, "R8", "tx_underrun", {31'h0, tx_underrun}, {31'h0, e_und});
        if (e_sv) begin
            chk(tx_sub_left === e_left, "R5", "tx_sub_left", {31'h0, tx_sub_left}, {31'h0, e_left});
            chk(tx_sub_slot === e_slot, sr, "tx_sub_slot", {8'h0, tx_sub_slot}, {8'h0, e_slot});
            chk({tx_sub_v, tx_sub_u, tx_sub_c} === {e_v, e_u, e_c},
                (cfg_width == 2'd3) ? "R3" : "R4", "tx_sub_vuc",
                {29'h0, tx_sub_v, tx_sub_u, tx_sub_c}, {29'h0, e_v, e_u, e_c});
            chk(tx_sub_p === e_p, (cfg_width == 2'd3) ? "R3" : "R4", "tx_sub_p",
                {31'h0, tx_sub_p}, {31'h0, e_p});
            chk(tx_sub_pre === e_pre, (cfg_width == 2'd3) ? "R3" : "R4", "tx_sub_pre",
                {28'h0, tx_sub_pre}, {28'h0, e_pre});
        end
        chk(rx_word_valid === m_wv, "R9", "rx_word_valid", {31'h0, rx_word_valid}, {31'h0, m_wv});
        if (m_wv)
            chk(rx_word === m_w, (cfg_pack && cfg_width == 2'd0) ? "R11" : "R9", "rx_word", rx_word, m_w);
        chk(rx_overrun === e_ovr, "R12", "rx_overrun", {31'h0, rx_overrun}, {31'h0, e_ovr});
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(negedge clk);
        if (fifo_pop) void'(fifo_q.pop_front());
        tx_valid = fifo_q.size() > 0;
        tx_word = (fifo_q.size() > 0) ? fifo_q[0] : 32'h0;
        tx_req = 0;
        rx_sub_valid = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) tick();
        chk(tx_sub_valid === 0 && tx_underrun === 0, "R1", "tx after reset",
            {30'h0, tx_sub_valid, tx_underrun}, 32'h0);
        chk(rx_word_valid === 0 && rx_overrun === 0, "R1", "rx after reset",
            {30'h0, rx_word_valid, rx_overrun}, 32'h0);
        rst_n = 1;
    endtask

    task automatic tx_run(input logic [1:0] wd, input bit pk, input int nwords,
                          input int nreq, input logic [31:0] seed);
        cfg_width = wd; cfg_pack = pk;
        for (int i = 0; i < nwords; i++) fifo_q.push_back(seed ^ (i * 32'h1357_9BDF));
        for (int i = 0; i < nreq; i++) begin
            tick();
            if (i % 4 != 3) begin
                tx_req = 1;
                tx_ubit = i[0]; tx_cbit = i[1]; tx_vflag = i[2];
            end
        end
        repeat (2) tick();
    endtask

    task automatic rx_send(input bit left, input logic [23:0] s, input logic [7:0] fl);
        tick();
        rx_sub_valid = 1; rx_sub_left = left; rx_sub_slot = s;
        {rx_sub_p, rx_sub_c, rx_sub_u, rx_sub_v, rx_sub_pre} = fl;
    endtask

    initial begin
        #(4ns * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        tick();
        chk(tx_ready === 0, "R1", "tx_ready idle", {31'h0, tx_ready}, 32'h0);
        // transmit: each width, packed, underrun
        tx_run(2'd0, 0, 5, 8, 32'hA5C3_7E19);
        tx_run(2'd1, 0, 5, 8, 32'h0F1E_2D3C);
        tx_run(2'd2, 0, 6, 8, 32'hFFFF_FFFF);
        tx_run(2'd3, 0, 6, 8, 32'h9ABC_DEF5);
        tx_run(2'd1, 1, 3, 5, 32'h1234_5678);
        tx_run(2'd0, 1, 3, 10, 32'hBEEF_CAFE);
        tx_run(2'd0, 1, 0, 3, 32'h0);
        tx_run(2'd0, 1, 2, 6, 32'h8001_7FFE);

        // receive, start on left
        cfg_rx_start_left = 1; cfg_pack = 0; cfg_width = 2'd0;
        do_reset();
        rx_send(0, 24'h111111, 8'h12);
        rx_send(0, 24'h222222, 8'h12);
        tick();
        chk(rx_word_valid === 0, "R10", "pre-lock discard", {31'h0, rx_word_valid}, 32'h0);
        for (int m = 0; m < 4; m++) begin
            cfg_width = m[1:0];
            for (int i = 0; i < 4; i++)
                rx_send(i[0] == 0, 24'hA5_5A00 ^ (i * 24'h13579B) ^ (m * 24'h2468), 8'h31 + 8'(i * 37));
            tick();
        end
        // overrun: hold word while more arrive
        cfg_width = 2'd2;
        rx_word_ready = 0;
        rx_send(1, 24'hC0FFEE, 8'hF3);
        rx_send(0, 24'hDEC0DE, 8'h82);
        rx_send(1, 24'h123456, 8'h41);
        tick(); tick();
        rx_word_ready = 1;
        tick(); tick();
        // packed receive, start left
        cfg_width = 2'd0; cfg_pack = 1;
        for (int i = 0; i < 6; i++) rx_send(i[0] == 0, 24'h3C_0000 + 24'(i * 24'h0B1D07), 8'h00);
        repeat (3) tick();
        // packed receive, start right
        cfg_rx_start_left = 0;
        do_reset();
        for (int i = 0; i < 7; i++) rx_send(i[0] == 0, 24'h7E_1200 ^ 24'(i * 24'h10F0F1), 8'h00);
        repeat (3) tick();
        // unpacked, start right, with ready throttling
        cfg_pack = 0; cfg_width = 2'd1;
        do_reset();
        rx_send(1, 24'h0ABCDE, 8'h55);
        tick();
        chk(rx_word_valid === 0, "R10", "left discarded when start right", {31'h0, rx_word_valid}, 32'h0);
        rx_word_ready = 0;
        rx_send(0, 24'hFEDCBA, 8'hA7);
        tick(); tick();
        rx_word_ready = 1;
        rx_send(1, 24'h13579B, 8'h1C);
        repeat (4) tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule